// File: doc/BRIEF.md
# Framed Stream ROT13 Transformer

This block sits on a 32-bit framed datagram stream and applies the rotate-by-thirteen letter substitution to the bytes of each datagram's payload. Each bus word holds four 8-bit characters, and all four are transformed in the same cycle. Header words, trailing padding and any byte that is not an ASCII letter leave the block exactly as they entered. Because a second pass of the same substitution restores the original text, one instance serves for both encryption and decryption.

A region state machine reads the framing markers (word valid, start of frame, start of payload data, end of payload) on every accepted word. It has four states. `ST_IDLE` is the state after reset. `ST_HEADER` covers a frame before its payload. `ST_PAYLOAD` covers the words inside the payload. `ST_TRAILER` covers the words after the payload. Its transitions are:

- Start (`ST_IDLE`/`ST_TRAILER` to `ST_HEADER`): start of frame without start of data.
- Open (`ST_HEADER` to `ST_PAYLOAD`): start of data.
- Direct open (any state to `ST_PAYLOAD`): start of frame and start of data on the same word.
- Close (`ST_PAYLOAD` or an opening word to `ST_TRAILER`): end of payload.
- Empty close (`ST_HEADER` to `ST_TRAILER`): end of payload seen before any start of data.
- Restart (`ST_PAYLOAD` to `ST_HEADER`): a start of frame arrives inside a payload.

Data and markers pass through a single output register. Backpressure from downstream is passed straight through to upstream.

Top module: `rot13_stream_xform`

## Requirements
- R1: Inside the payload, each byte 0x41–0x4D or 0x61–0x6D has 13 added, and each byte 0x4E–0x5A or 0x6E–0x7A has 13 subtracted ('A'→'N', 'M'→'Z', 'n'→'a', 'z'→'m').
- R2: Every byte that is not an ASCII letter passes unchanged, also inside the payload. This includes the neighbours 0x40, 0x5B, 0x60 and 0x7B and all values of 0x80 and above.
- R3: The four byte lanes, bits [8k+7:8k] for k = 0..3, are transformed independently and in the same cycle.
- R4: The payload starts on an accepted word that has start of data high while in `ST_HEADER` or together with start of frame. It ends with the accepted word that has end of payload high, and that word is included. Header words are never transformed.
- R5: Words after the end of payload are not transformed until the next start of frame. A start of data without start of frame in that interval is ignored.
- R6: A start of frame inside a payload begins a new frame. That word is treated as header unless start of data is also high.
- R7: Data, valid and the three markers appear on the outputs exactly one clock after they are accepted. Markers are output as 0 on words whose valid is low.
- R8: `in_rdy` follows `out_rdy` combinationally. While `out_rdy` is low, all outputs hold and the region state does not advance.
- R9: A word with valid low does not advance the region state and is output with `out_valid` low.
- R10: Reset clears `out_valid` and all output markers and returns the region state to `ST_IDLE`, so the next unframed word is not transformed.
- R11: Passing transformed payload through the block a second time returns the original bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Incoming word, four characters |
| in_valid | input | 1 | Incoming word is valid |
| in_sof | input | 1 | First word of a frame |
| in_sod | input | 1 | First word of the payload |
| in_eof | input | 1 | Last word of the payload |
| in_rdy | output | 1 | Block can accept a word this cycle |
| out_data | output | 32 | Outgoing word |
| out_valid | output | 1 | Outgoing word is valid |
| out_sof | output | 1 | Registered start of frame |
| out_sod | output | 1 | Registered start of payload |
| out_eof | output | 1 | Registered end of payload |
| out_rdy | input | 1 | Downstream can take a word |

## Verification
A frame whose header holds letters shows that the region machine keeps headers intact. Payload words that mix both alphabet halves with the bytes just outside each letter range separate the add branch, the subtract branch and pass-through on each lane. Padding words, a stray start of data in the trailer, a single-word payload and a frame restarted mid-payload test each state transition. A stalled stream with marker changes, an invalid gap inside the payload, a reset in mid-payload and a second pass over encoded text check the hold, gap, reset and involution behaviour.

// File: rtl/rot13_stream_pkg.sv
package rot13_stream_pkg;

    localparam int CHAR_W   = 8;
    localparam int ROT_STEP = 13;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HEADER  = 2'd1,
        ST_PAYLOAD = 2'd2,
        ST_TRAILER = 2'd3
    } region_e;

    typedef struct packed {
        logic sof;
        logic sod;
        logic eof;
    } mark_t;

endpackage

// File: rtl/rot13_lane.sv
module rot13_lane
    import rot13_stream_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic [W-1:0] char_in,
    input  logic         xform_en,
    output logic [W-1:0] char_out
);
    localparam logic [W-1:0] CASE_BIT = W'(8'h20);
    localparam logic [W-1:0] LOW_A    = W'(8'h61);
    localparam logic [W-1:0] LOW_M    = W'(8'h6D);
    localparam logic [W-1:0] LOW_Z    = W'(8'h7A);
    localparam logic [W-1:0] STEP     = W'(ROT_STEP);

    logic [W-1:0] folded;
    logic         is_alpha;
    logic         first_half;

    always_comb begin
        folded     = char_in | CASE_BIT;
        is_alpha   = (folded >= LOW_A) && (folded <= LOW_Z);
        first_half = (folded <= LOW_M);
        if (xform_en && is_alpha)
            char_out = first_half ? (char_in + STEP) : (char_in - STEP);
        else
            char_out = char_in;
    end
endmodule

// File: rtl/rot13_region_fsm.sv
module rot13_region_fsm
    import rot13_stream_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    word_valid,
    input  logic    word_take,
    input  mark_t   marks,
    output logic    xform_en
);
    region_e state_q;
    region_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (word_take && word_valid)
            state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        xform_en = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TRAILER: begin
                if (marks.sof) begin
                    if (marks.sod) begin
                        xform_en = 1'b1;
                        state_d  = marks.eof ? ST_TRAILER : ST_PAYLOAD;
                    end else begin
                        state_d  = ST_HEADER;
                    end
                end
            end
            ST_HEADER: begin
                if (marks.sod) begin
                    xform_en = 1'b1;
                    state_d  = marks.eof ? ST_TRAILER : ST_PAYLOAD;
                end else if (marks.eof) begin
                    state_d  = ST_TRAILER;
                end
            end
            ST_PAYLOAD: begin
                if (marks.sof && !marks.sod) begin
                    state_d  = ST_HEADER;
                end else begin
                    xform_en = 1'b1;
                    if (marks.eof)
                        state_d = ST_TRAILER;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (!word_valid)
            xform_en = 1'b0;
    end
endmodule

// File: rtl/rot13_out_stage.sv
module rot13_out_stage
    import rot13_stream_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] nxt_data,
    input  logic              nxt_valid,
    input  mark_t             nxt_marks,
    output logic [DATA_W-1:0] q_data,
    output logic              q_valid,
    output mark_t             q_marks
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data  <= '0;
            q_valid <= 1'b0;
            q_marks <= '0;
        end else if (load) begin
            q_data  <= nxt_data;
            q_valid <= nxt_valid;
            q_marks <= nxt_valid ? nxt_marks : '0;
        end
    end
endmodule

// File: rtl/rot13_stream_xform.sv
module rot13_stream_xform
    import rot13_stream_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sod,
    input  logic              in_eof,
    output logic              in_rdy,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_sod,
    output logic              out_eof,
    input  logic              out_rdy
);
    localparam int LANES = DATA_W / CHAR_W;

    mark_t             in_marks;
    mark_t             q_marks;
    logic              xform_en;
    logic [DATA_W-1:0] xdata;

    assign in_marks = '{sof: in_sof, sod: in_sod, eof: in_eof};
    assign in_rdy   = out_rdy;

    rot13_region_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (in_valid),
        .word_take  (out_rdy),
        .marks      (in_marks),
        .xform_en   (xform_en)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        rot13_lane #(.W(CHAR_W)) u_lane (
            .char_in  (in_data[k*CHAR_W +: CHAR_W]),
            .xform_en (xform_en),
            .char_out (xdata[k*CHAR_W +: CHAR_W])
        );
    end

    rot13_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (out_rdy),
        .nxt_data  (xdata),
        .nxt_valid (in_valid),
        .nxt_marks (in_marks),
        .q_data    (out_data),
        .q_valid   (out_valid),
        .q_marks   (q_marks)
    );

    assign out_sof = q_marks.sof;
    assign out_sod = q_marks.sod;
    assign out_eof = q_marks.eof;
endmodule

// File: rtl/rot13_stream_xform_chk.sv
module rot13_stream_xform_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_sof,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_sof,
    input logic              out_rdy
);
    localparam int LANES = DATA_W / 8;

    function automatic logic upper_f(input logic [7:0] b);
        return (b >= 8'h41) && (b <= 8'h5A);
    endfunction

    function automatic logic letter_f(input logic [7:0] b);
        return upper_f(b) || ((b >= 8'h61) && (b <= 8'h7A));
    endfunction

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_rdy) |-> (out_valid == $past(in_valid)));

    assert_sof_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_rdy) |-> (out_sof == $past(in_sof && in_valid)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(out_rdy) |-> ($stable(out_data) && $stable(out_valid)));

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        assert_nonletter_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(out_rdy) && !letter_f($past(in_data[k*8 +: 8])))
            |-> (out_data[k*8 +: 8] == $past(in_data[k*8 +: 8])));

        assert_case_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(out_rdy) && upper_f($past(in_data[k*8 +: 8])))
            |-> upper_f(out_data[k*8 +: 8]));
    end
endmodule

bind rot13_stream_xform rot13_stream_xform_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_rdy   (out_rdy)
);

// File: tb/rot13_stream_xform_tb.sv
module rot13_stream_xform_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_sod = 1'b0, in_eof = 1'b0;
    logic        in_rdy;
    logic [31:0] out_data;
    logic        out_valid, out_sof, out_sod, out_eof;
    logic        out_rdy = 1'b1;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rot13_stream_xform dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid),
        .in_sof(in_sof), .in_sod(in_sod), .in_eof(in_eof), .in_rdy(in_rdy),
        .out_data(out_data), .out_valid(out_valid),
        .out_sof(out_sof), .out_sod(out_sod), .out_eof(out_eof),
        .out_rdy(out_rdy)
    );

    // {sof, sod, eof, input word, expected word}
    localparam int NV = 15;
    localparam logic [66:0] VEC [NV] = '{
        {3'b100, 32'h48656C6C, 32'h48656C6C},  // R4 header kept
        {3'b000, 32'h0A0B0C0D, 32'h0A0B0C0D},  // R4 header kept
        {3'b010, 32'h48656C6C, 32'h55727979},  // R1 R4 payload opens
        {3'b000, 32'h6F2C2057, 32'h622C204A},  // R1 R2 R3 mixed lanes
        {3'b000, 32'h404D5B60, 32'h405A5B60},  // R2 range neighbours
        {3'b000, 32'h7B6E80C1, 32'h7B6180C1},  // R2 high bytes
        {3'b001, 32'h414D4E5A, 32'h4E5A414D},  // R1 R4 last payload word
        {3'b000, 32'h61626364, 32'h61626364},  // R5 padding
        {3'b010, 32'h61626364, 32'h61626364},  // R5 stray sod ignored
        {3'b111, 32'h616D6E7A, 32'h6E7A616D},  // R4 one-word payload
        {3'b100, 32'h55727979, 32'h55727979},  // R4 header
        {3'b010, 32'h55727979, 32'h48656C6C},  // R11 second pass
        {3'b100, 32'h6E6E6E6E, 32'h6E6E6E6E},  // R6 restart inside payload
        {3'b011, 32'h6E6E6E6E, 32'h61616161},  // R4 R6 new payload
        {3'b000, 32'h41414141, 32'h41414141}   // R5 trailer
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input bit s, input bit d, input bit e,
                         input logic [31:0] w);
        in_valid = v; in_sof = s; in_sod = d; in_eof = e; in_data = w;
    endtask

    initial begin
        #160000;
        failures++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_sof == 0 && out_sod == 0 && out_eof == 0,
              "R10 reset outputs", {28'h0, out_valid, out_sof, out_sod, out_eof}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, VEC[i][66], VEC[i][65], VEC[i][64], VEC[i][63:32]);
            @(negedge clk);
            check(out_data == VEC[i][31:0], "R1-table data", out_data, VEC[i][31:0]);
            check(out_valid && out_sof == VEC[i][66] && out_sod == VEC[i][65]
                  && out_eof == VEC[i][64], "R7 markers",
                  {28'h0, out_valid, out_sof, out_sod, out_eof},
                  {28'h0, 1'b1, VEC[i][66:64]});
            drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        end

        // R8 stall: header then stalled payload words
        @(negedge clk); drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h11223344);
        @(negedge clk); held = out_data;
        out_rdy = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 1'b1, 32'h41414141);
        #1;
        check(in_rdy == 1'b0, "R8 ready follows", {31'h0, in_rdy}, 32'h0);
        @(negedge clk);
        check(out_data == held && out_valid, "R8 hold", out_data, held);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 32'h61616161);
        @(negedge clk);
        check(out_data == held && !out_eof, "R8 hold markers", out_data, held);
        out_rdy = 1'b1;
        drive(1'b1, 1'b0, 1'b1, 1'b0, 32'h41414141);
        @(negedge clk);
        check(out_data == 32'h4E4E4E4E, "R8 state held through stall", out_data, 32'h4E4E4E4E);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 32'h41414141);
        @(negedge clk);
        check(!out_valid && !out_eof, "R9 gap invalid", {31'h0, out_valid}, 32'h0);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 32'h41414141);
        @(negedge clk);
        check(out_data == 32'h4E4E4E4E, "R9 gap kept payload", out_data, 32'h4E4E4E4E);

        // R10 reset mid-payload
        drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check(!out_valid, "R10 reset valid", {31'h0, out_valid}, 32'h0);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 32'h41414141);
        @(negedge clk);
        check(out_data == 32'h41414141, "R10 idle after reset", out_data, 32'h41414141);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule